// File: doc/BRIEF.md
# Square-Wave Dual-Tone Frequency Classifier

This block sits behind the analog front end of a touch-tone receiver. It takes two digital inputs. One is the limited square wave from the low-band filter and the other is the limited square wave from the high-band filter. The block measures the edge-to-edge period of each wave by counting clock cycles. It adds up a fixed number of consecutive periods and compares that sum with a precomputed acceptance window for each of the four nominal tones of the band.

A band is valid only when the latest sum falls inside the window of exactly one tone. When both bands are valid, the block raises an early steering flag and latches a 4-bit code for the tone pair. The flag drops as soon as either band loses validity. A band loses validity when a measured sum falls outside every window, or when its input stops toggling for too long. Guard-time qualification and serial readout belong to downstream blocks.

The clock is nominally 4.194304 MHz. The clock rate, the number of averaged periods, the window tolerance and the synchroniser depth are parameters.

Top module: `dtmf_tone_classifier`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `steer_o` is 0 and `code_o` is 4'b0000.
- R2: Low tones 697, 770 and 852 Hz have row numbers 0, 1 and 2. High tones 1209, 1336 and 1477 Hz have column numbers 0, 1 and 2. For these pairs, `code_o` equals 3*row + column + 1, which gives 4'b0001 through 4'b1001.
- R3: With 941 Hz in the low band, the code is 4'b1011 for 1209 Hz, 4'b1010 for 1336 Hz and 4'b1100 for 1477 Hz.
- R4: With 1633 Hz in the high band, the code is 4'b1101 for 697 Hz, 4'b1110 for 770 Hz, 4'b1111 for 852 Hz and 4'b0000 for 941 Hz.
- R5: A tone whose frequency is off nominal by up to ±(1.5 % + 2 Hz) in either band is accepted and produces the code of its nominal pair.
- R6: A tone that is 3.5 % or more away from every nominal tone of its band never raises `steer_o`.
- R7: `steer_o` rises only after both bands have been judged valid. A single band alone never raises it.
- R8: `steer_o` falls when a band loses validity. A band loses validity when a measured sum lands outside every window, or when its input shows no rising edge for twice the longest nominal period of that band. The flag falls one cycle after the band is marked invalid.
- R9: Validity is decided on the sum of NPER (default 4) consecutive full periods, never on a single period. After a tone starts from silence, `steer_o` stays low for at least NPER-1 periods of the low tone.
- R10: `code_o` changes only in the cycle in which `steer_o` rises. It holds while `steer_o` is high and keeps its value after `steer_o` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, nominally 4.194304 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_sq_i | input | 1 | Limited square wave of the low tone band (asynchronous) |
| hi_sq_i | input | 1 | Limited square wave of the high tone band (asynchronous) |
| steer_o | output | 1 | Early steering flag: both bands currently valid |
| code_o | output | 4 | Code of the tone pair, latched when `steer_o` rises |

## Verification
Suppose a period counter or window bound inside the block is wrong. The first visible effect is on `steer_o`: it fails to rise within about five low-tone periods of a nominal pair, or it rises on a detuned tone. Suppose instead the block decides validity on a partial sum. Then `steer_o` rises before NPER-1 low periods have passed. A fault in code translation or in the hold register shows up in `code_o`, either at the rise of `steer_o` or while the flag is held. A missing timeout shows up as a flag that stays high well past two periods of the longest low tone after the inputs fall silent.

// File: rtl/dtmf_cls_pkg.sv
package dtmf_cls_pkg;

   localparam int NTONE = 4;
   localparam int IDXW  = 2;
   localparam int CODEW = 4;

   // nominal tone frequency in Hz; grp 0 = low band, grp 1 = high band
   function automatic int nominal_hz(int grp, int idx);
      int f;
      f = 0;
      if (grp == 0) begin
         case (idx)
            0: f = 697;
            1: f = 770;
            2: f = 852;
            default: f = 941;
         endcase
      end else begin
         case (idx)
            0: f = 1209;
            1: f = 1336;
            2: f = 1477;
            default: f = 1633;
         endcase
      end
      return f;
   endfunction

   // smallest accepted sum of nper periods (tone faster by tol permille)
   function automatic longint win_lo(longint clk_hz, int nper, int tol, int f);
      return (longint'(nper) * clk_hz * 64'd1000) / (longint'(f) * longint'(1000 + tol));
   endfunction

   // largest accepted sum of nper periods (tone slower by tol permille)
   function automatic longint win_hi(longint clk_hz, int nper, int tol, int f);
      return (longint'(nper) * clk_hz * 64'd1000) / (longint'(f) * longint'(1000 - tol));
   endfunction

   // silence timeout: two periods of the slowest tone of the band
   function automatic int tmo_cycles(longint clk_hz, int grp);
      return int'((64'd2 * clk_hz) / longint'(nominal_hz(grp, 0)));
   endfunction

   // row index r (low band), column index c (high band) to pair code
   function automatic logic [CODEW-1:0] pair_code(logic [IDXW-1:0] r, logic [IDXW-1:0] c);
      logic [CODEW-1:0] v;
      if (c == 2'd3) begin
         v = (r == 2'd3) ? 4'd0 : 4'(13 + int'(r));
      end else if (r != 2'd3) begin
         v = 4'(3 * int'(r) + int'(c) + 1);
      end else begin
         case (c)
            2'd0:    v = 4'd11;
            2'd1:    v = 4'd10;
            default: v = 4'd12;
         endcase
      end
      return v;
   endfunction

endpackage

// File: rtl/dtmf_sq_sync.sv
module dtmf_sq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sq_i,
   output logic rise_o
);
   logic [STAGES:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= {pipe_q[STAGES-1:0], sq_i};
   end

   // rising edge seen between the last synchroniser stage and its follower
   assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

endmodule

// File: rtl/dtmf_period_meter.sv
module dtmf_period_meter #(
   parameter int CW   = 14,
   parameter int SW   = 16,
   parameter int NPER = 4,
   parameter int TMO  = 12000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rise_i,
   output logic [SW-1:0] sum_o,
   output logic          sum_vld_o,
   output logic          tmo_o
);
   localparam int NW = (NPER > 2) ? $clog2(NPER) : 1;

   logic          armed_q;
   logic [CW-1:0] cnt_q;
   logic [SW-1:0] acc_q;
   logic [NW-1:0] nper_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q   <= 1'b0;
         cnt_q     <= '0;
         acc_q     <= '0;
         nper_q    <= '0;
         sum_o     <= '0;
         sum_vld_o <= 1'b0;
         tmo_o     <= 1'b0;
      end else begin
         sum_vld_o <= 1'b0;
         tmo_o     <= 1'b0;
         if (rise_i) begin
            armed_q <= 1'b1;
            cnt_q   <= CW'(1);
            if (armed_q) begin
               if (nper_q == NW'(NPER - 1)) begin
                  sum_o     <= acc_q + SW'(cnt_q);
                  sum_vld_o <= 1'b1;
                  acc_q     <= '0;
                  nper_q    <= '0;
               end else begin
                  acc_q  <= acc_q + SW'(cnt_q);
                  nper_q <= nper_q + 1'b1;
               end
            end
         end else if (armed_q) begin
            if (cnt_q == CW'(TMO)) begin
               armed_q <= 1'b0;
               cnt_q   <= '0;
               acc_q   <= '0;
               nper_q  <= '0;
               tmo_o   <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/dtmf_window_match.sv
module dtmf_window_match
   import dtmf_cls_pkg::*;
#(
   parameter longint CLK_HZ = 4194304,
   parameter int     NPER   = 4,
   parameter int     TOL    = 25,
   parameter int     GRP    = 0,
   parameter int     SW     = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [SW-1:0]   sum_i,
   input  logic            sum_vld_i,
   input  logic            tmo_i,
   output logic            ok_o,
   output logic [IDXW-1:0] idx_o
);
   logic [NTONE-1:0] hit;
   logic [IDXW-1:0]  enc;

   for (genvar t = 0; t < NTONE; t++) begin : g_win
      localparam logic [SW-1:0] W_LO = SW'(win_lo(CLK_HZ, NPER, TOL, nominal_hz(GRP, t)));
      localparam logic [SW-1:0] W_HI = SW'(win_hi(CLK_HZ, NPER, TOL, nominal_hz(GRP, t)));
      assign hit[t] = (sum_i >= W_LO) && (sum_i <= W_HI);
   end

   always_comb begin
      enc = '0;
      for (int t = 0; t < NTONE; t++) begin
         if (hit[t]) enc = IDXW'(t);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ok_o  <= 1'b0;
         idx_o <= '0;
      end else if (tmo_i) begin
         ok_o <= 1'b0;
      end else if (sum_vld_i) begin
         ok_o  <= ($countones(hit) == 1);
         idx_o <= enc;
      end
   end

endmodule

// File: rtl/dtmf_steer.sv
module dtmf_steer
   import dtmf_cls_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lo_ok_i,
   input  logic [IDXW-1:0]  lo_idx_i,
   input  logic             hi_ok_i,
   input  logic [IDXW-1:0]  hi_idx_i,
   output logic             steer_o,
   output logic [CODEW-1:0] code_o
);
   logic both;
   assign both = lo_ok_i & hi_ok_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         steer_o <= 1'b0;
         code_o  <= '0;
      end else begin
         steer_o <= both;
         if (both && !steer_o) code_o <= pair_code(lo_idx_i, hi_idx_i);
      end
   end

endmodule

// File: rtl/dtmf_tone_classifier.sv
module dtmf_tone_classifier
   import dtmf_cls_pkg::*;
#(
   parameter longint CLK_HZ       = 4194304,
   parameter int     NPER         = 4,
   parameter int     TOL_PERMILLE = 25,
   parameter int     SYNC_STAGES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lo_sq_i,
   input  logic             hi_sq_i,
   output logic             steer_o,
   output logic [CODEW-1:0] code_o
);
   localparam int TMO_MAX = tmo_cycles(CLK_HZ, 0);
   localparam int CW      = $clog2(TMO_MAX + 1);
   localparam int SW      = CW + $clog2(NPER) + 1;

   if (NPER < 2 || NPER > 16) begin : g_bad_nper
      $error("NPER must lie in 2..16");
   end
   if (TOL_PERMILLE < 20 || TOL_PERMILLE > 33) begin : g_bad_tol
      $error("TOL_PERMILLE must lie in 20..33");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (CLK_HZ < 64'd100000) begin : g_bad_clk
      $error("CLK_HZ too low for period counting");
   end

   logic [1:0]          sq;
   logic [1:0]          rise;
   logic [1:0][SW-1:0]  sum;
   logic [1:0]          sum_vld;
   logic [1:0]          tmo;
   logic [1:0]          grp_ok;
   logic [1:0][IDXW-1:0] grp_idx;

   assign sq = {hi_sq_i, lo_sq_i};

   for (genvar g = 0; g < 2; g++) begin : g_band
      localparam int TMO_G = tmo_cycles(CLK_HZ, g);

      dtmf_sq_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk    (clk),
         .rst_n  (rst_n),
         .sq_i   (sq[g]),
         .rise_o (rise[g])
      );

      dtmf_period_meter #(.CW(CW), .SW(SW), .NPER(NPER), .TMO(TMO_G)) u_meter (
         .clk       (clk),
         .rst_n     (rst_n),
         .rise_i    (rise[g]),
         .sum_o     (sum[g]),
         .sum_vld_o (sum_vld[g]),
         .tmo_o     (tmo[g])
      );

      dtmf_window_match #(
         .CLK_HZ (CLK_HZ),
         .NPER   (NPER),
         .TOL    (TOL_PERMILLE),
         .GRP    (g),
         .SW     (SW)
      ) u_match (
         .clk       (clk),
         .rst_n     (rst_n),
         .sum_i     (sum[g]),
         .sum_vld_i (sum_vld[g]),
         .tmo_i     (tmo[g]),
         .ok_o      (grp_ok[g]),
         .idx_o     (grp_idx[g])
      );
   end

   dtmf_steer u_steer (
      .clk      (clk),
      .rst_n    (rst_n),
      .lo_ok_i  (grp_ok[0]),
      .lo_idx_i (grp_idx[0]),
      .hi_ok_i  (grp_ok[1]),
      .hi_idx_i (grp_idx[1]),
      .steer_o  (steer_o),
      .code_o   (code_o)
   );

endmodule

// File: rtl/dtmf_cls_checker.sv
module dtmf_cls_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       steer,
   input logic [3:0] code,
   input logic       lo_ok,
   input logic       hi_ok,
   input logic       lo_vld,
   input logic       hi_vld,
   input logic       lo_tmo,
   input logic       hi_tmo
);

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (!steer && code == 4'd0));

   assert_steer_needs_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(steer) |-> $past(lo_ok && hi_ok));

   assert_steer_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(lo_ok && hi_ok) |=> !steer);

   assert_lo_tmo_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lo_tmo |=> !lo_ok);

   assert_hi_tmo_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hi_tmo |=> !hi_ok);

   assert_lo_from_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo_ok) |-> $past(lo_vld));

   assert_hi_from_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_ok) |-> $past(hi_vld));

   assert_code_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(steer) |-> $stable(code));

endmodule

bind dtmf_tone_classifier dtmf_cls_checker u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .steer  (steer_o),
   .code   (code_o),
   .lo_ok  (grp_ok[0]),
   .hi_ok  (grp_ok[1]),
   .lo_vld (sum_vld[0]),
   .hi_vld (sum_vld[1]),
   .lo_tmo (tmo[0]),
   .hi_tmo (tmo[1])
);

// File: tb/dtmf_tone_classifier_bench.sv
`timescale 1ns/1ps
module dtmf_tone_classifier_bench;
   localparam longint CLK_HZ = 419430;   // scaled clock keeps the run short

   logic       clk;
   logic       rst_n;
   logic       lo_sq, hi_sq;
   logic       steer;
   logic [3:0] code;

   int total = 0;
   int bad   = 0;
   int lo_per = 0;
   int hi_per = 0;

   real lo_tab [4] = '{697.0, 770.0, 852.0, 941.0};
   real hi_tab [4] = '{1209.0, 1336.0, 1477.0, 1633.0};

   dtmf_tone_classifier #(.CLK_HZ(CLK_HZ)) u_dtmf_tone_classifier (
      .clk     (clk),
      .rst_n   (rst_n),
      .lo_sq_i (lo_sq),
      .hi_sq_i (hi_sq),
      .steer_o (steer),
      .code_o  (code)
   );

   initial clk = 1'b0;
   always #4 clk = ~clk;

   // square-wave generators, periods in clock cycles (0 = silent)
   initial begin
      lo_sq = 1'b0;
      forever begin
         if (lo_per == 0) begin
            lo_sq = 1'b0;
            @(posedge clk); #1;
         end else begin
            automatic int p = lo_per;
            lo_sq = 1'b1;
            repeat (p / 2) begin @(posedge clk); #1; end
            lo_sq = 1'b0;
            repeat (p - p / 2) begin @(posedge clk); #1; end
         end
      end
   end

   initial begin
      hi_sq = 1'b0;
      forever begin
         if (hi_per == 0) begin
            hi_sq = 1'b0;
            @(posedge clk); #1;
         end else begin
            automatic int p = hi_per;
            hi_sq = 1'b1;
            repeat (p / 2) begin @(posedge clk); #1; end
            hi_sq = 1'b0;
            repeat (p - p / 2) begin @(posedge clk); #1; end
         end
      end
   end

   function automatic int per_of(real f);
      return $rtoi(real'(CLK_HZ) / f + 0.5);
   endfunction

   // expected pair code written from the requirement tables
   function automatic int exp_code(int r, int c);
      int v;
      case ({r[1:0], c[1:0]})
         4'b0000: v = 1;  4'b0001: v = 2;  4'b0010: v = 3;  4'b0011: v = 13;
         4'b0100: v = 4;  4'b0101: v = 5;  4'b0110: v = 6;  4'b0111: v = 14;
         4'b1000: v = 7;  4'b1001: v = 8;  4'b1010: v = 9;  4'b1011: v = 15;
         4'b1100: v = 11; 4'b1101: v = 10; 4'b1110: v = 12; default: v = 0;
      endcase
      return v;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // wait at most maxc cycles for steer to reach lvl; returns cycles taken or -1
   task automatic wait_steer(bit lvl, int maxc, output int took);
      took = -1;
      for (int i = 0; i < maxc; i++) begin
         @(negedge clk);
         if (steer == lvl) begin took = i; break; end
      end
   endtask

   task automatic silence();
      lo_per = 0;
      hi_per = 0;
      repeat (2500) @(negedge clk);
   endtask

   task automatic t_reset_R1();
      rst_n = 1'b0;
      repeat (5) @(negedge clk);
      chk(steer == 1'b0, "R1 steer in reset", steer, 0);
      chk(code == 4'd0, "R1 code in reset", code, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(steer == 1'b0 && code == 4'd0, "R1 after release", {steer, code}, 0);
   endtask

   task automatic t_pair(real lf, real hf, int ec, string req);
      int took;
      int held;
      lo_per = per_of(lf);
      hi_per = per_of(hf);
      wait_steer(1'b1, 8000, took);
      chk(took >= 0, {req, " steer rise"}, took, 1);
      chk(code == 4'(ec), {req, " code"}, code, ec);
      held = code;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (code != 4'(held) || !steer) begin
            chk(1'b0, "R10 code held while steer high", code, held);
            break;
         end
      end
      lo_per = 0;
      hi_per = 0;
      wait_steer(1'b0, 2000, took);
      chk(took >= 0, "R8 steer falls after silence", took, 1);
      chk(code == 4'(held), "R10 code kept after steer falls", code, held);
      silence();
   endtask

   task automatic t_all_digits();
      for (int r = 0; r < 4; r++) begin
         for (int c = 0; c < 4; c++) begin
            string req;
            req = (c == 3) ? "R4" : ((r == 3) ? "R3" : "R2");
            t_pair(lo_tab[r], hi_tab[c], exp_code(r, c), req);
         end
      end
   endtask

   task automatic t_tolerance_R5();
      t_pair(697.0 * 1.015 + 2.0, 1633.0 * 0.985 - 2.0, 13, "R5 edge A");
      t_pair(941.0 * 0.985 - 2.0, 1209.0 * 1.015 + 2.0, 11, "R5 edge star");
   endtask

   task automatic t_reject_R6();
      int took;
      lo_per = per_of(697.0 * 1.035);
      hi_per = per_of(1209.0);
      wait_steer(1'b1, 8000, took);
      chk(took < 0, "R6 low band +3.5% rejected", took, -1);
      silence();
      lo_per = per_of(852.0);
      hi_per = per_of(1633.0 * 0.965);
      wait_steer(1'b1, 8000, took);
      chk(took < 0, "R6 high band -3.5% rejected", took, -1);
      silence();
   endtask

   task automatic t_single_band_R7();
      int took;
      lo_per = per_of(770.0);
      hi_per = 0;
      wait_steer(1'b1, 8000, took);
      chk(took < 0, "R7 low band alone", took, -1);
      silence();
      lo_per = 0;
      hi_per = per_of(1336.0);
      wait_steer(1'b1, 6000, took);
      chk(took < 0, "R7 high band alone", took, -1);
      silence();
   endtask

   task automatic t_average_R9();
      int took;
      int lp;
      lp = per_of(697.0);
      lo_per = lp;
      hi_per = per_of(1209.0);
      wait_steer(1'b1, 3 * lp, took);
      chk(took < 0, "R9 no decision within 3 periods", took, -1);
      wait_steer(1'b1, 6000, took);
      chk(took >= 0, "R9 decision after full sum", took, 1);
      chk(code == 4'd1, "R9 code", code, 1);
      silence();
   endtask

   task automatic t_detune_drop_R8();
      int took;
      lo_per = per_of(852.0);
      hi_per = per_of(1336.0);
      wait_steer(1'b1, 8000, took);
      chk(took >= 0 && code == 4'd8, "R8 setup pair 8", code, 8);
      lo_per = per_of(852.0 * 1.035);
      wait_steer(1'b0, 5000, took);
      chk(took >= 0, "R8 steer falls on detuned low band", took, 1);
      chk(code == 4'd8, "R10 code kept after detune", code, 8);
      silence();
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      t_reset_R1();
      t_all_digits();
      t_tolerance_R5();
      t_reject_R6();
      t_single_band_R7();
      t_average_R9();
      t_detune_drop_R8();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule